// File: doc/BRIEF.md
# Serial Transmit Path with Holding Queue

This block is the transmit half of a byte-oriented asynchronous serial port that sits on a host register bus. The host writes configuration registers (baud divisor, line format, queue mode, interrupt enable, clock prescale) and pushes characters through a data register. Characters wait in a holding stage and are handed one at a time to a shift register. The shift register frames each character with a start bit, 5 to 8 data bits, optional parity and one or two stop bits, and drives them onto the serial line.

The holding stage is either a single-byte holding register or a 16-entry first-in first-out queue, chosen by a control bit. The serial timing comes from a 16x tick. That tick is the input clock divided by a 16-bit divisor, optionally after a fixed divide-by-4 prescaler. Two status outputs tell the host whether the holding stage has room and whether the whole transmitter has gone quiet. An interrupt output, gated by an enable bit, asks for more data.

Top module: `uart_tx_path`

## Requirements
- R1: Out of reset, txd_o is 1, thr_empty_o and tx_empty_o are 1, and irq_o is 0. The divisor, line format, queue mode, interrupt enable and prescale all reset to 0. Whenever the transmitter is empty, the line is 1.
- R2: A frame is one start bit (0), then the data bits least significant first, then an optional parity bit and the stop bits (1). The data bit count is 5 + line-register bits [1:0] (address 3). Data bits above the word length are not sent.
- R3: Line-register bit 3 enables parity. Bit 4 selects odd parity (1) or even parity (0), computed over the transmitted data bits.
- R4: Line-register bit 2 selects two stop bits (1) or one stop bit (0). The transmitter becomes empty exactly when the frame's last stop bit has lasted one full bit time.
- R5: Each bit lasts 16 baud ticks. A baud tick comes once every D input clocks, where D is the 16-bit divisor with its low byte at address 1 and its high byte at address 2.
- R6: When clock-register bit 7 (address 6) is 1, the input clock is divided by 4 before the divisor is applied, so each bit lasts 64·D clocks.
- R7: A divisor of 0 stops the baud ticks. A pending byte is not sent and the line holds its level until a nonzero divisor is written.
- R8: When queue-register bit 0 (address 4) is 1, up to 16 bytes written to the data register (address 0) are sent in write order. A write while 16 bytes are waiting is dropped. Changing this bit empties the holding stage.
- R9: When queue-register bit 0 is 0, only one byte can wait. A second write before that byte has moved into the shift register is dropped.
- R10: thr_empty_o goes to 0 in the cycle after a data write and returns to 1 when the byte is handed to the shift register. tx_empty_o is 1 only when nothing is waiting and no frame is in progress.
- R11: irq_o is 1 exactly when interrupt-register bit 1 (address 5) is set and thr_empty_o is 1.
- R12: When another byte is waiting at the end of a frame, the next start bit follows the last stop bit with no idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| txd_o | output | 1 | Serial output, idles at 1 |
| thr_empty_o | output | 1 | Holding stage empty |
| tx_empty_o | output | 1 | Holding stage and shift register both empty |
| irq_o | output | 1 | Transmit-empty interrupt |

## Verification
Register writes take effect at the clock edge that samples them. The flags change on that same edge, so the bench reads them at the next falling edge. With divisor 1, the load tick comes on the edge after the write, and the start bit appears on txd_o one edge later. The bench therefore triggers on the falling edge at which it first sees txd_o low and counts falling edges from there. It samples each bit at half a bit time plus whole bit times (bit time = 16·D, or 64·D when prescaled). It expects tx_empty_o exactly frame-length × bit-time edges after the start, and consecutive starts exactly one frame apart.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_DIV_LO = 3'd1,
    REG_DIV_HI = 3'd2,
    REG_LINE   = 3'd3,
    REG_QUEUE  = 3'd4,
    REG_INT_EN = 3'd5,
    REG_CLK    = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic       par_odd;
    logic       par_en;
    logic       stop2;
    logic [1:0] wlen;
  } line_cfg_t;

  localparam int unsigned FRAME_W = 12;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned PRE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pre_en_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] cnt_q;
  logic             pre_stb, div_nz, at_end;

  assign pre_stb = pre_en_i ? (pre_q == {PRE_W{1'b1}}) : 1'b1;
  assign div_nz  = (div_i != '0);
  assign at_end  = (cnt_q >= div_i - 1'b1);
  assign tick_o  = pre_stb && div_nz && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (pre_stb && div_nz) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             q_en_i,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    data_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [LVL_W-1:0] lvl_q, cap;
  logic             full, do_push, do_pop;

  assign cap     = q_en_i ? LVL_W'(DEPTH) : LVL_W'(1);
  assign full    = (lvl_q >= cap);
  assign empty_o = (lvl_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];
  assign level_o = lvl_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (do_push && !flush_i && wp_q == PTR_W'(g)) mem_q[g] <= data_i;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  line_cfg_t cfg_i,
  input  logic      avail_i,
  input  logic [7:0] data_i,
  output logic      pop_o,
  output logic      busy_o,
  output logic      txd_o
);
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [3:0]         left_q, len_d, sub_q, nbits;
  logic               busy_q, ending, load, par_bit;
  logic [7:0]         mask;

  assign nbits   = 4'd5 + {2'b00, cfg_i.wlen};
  assign mask    = 8'hFF >> (2'd3 - cfg_i.wlen);
  assign par_bit = (^(data_i & mask)) ^ cfg_i.par_odd;
  assign len_d   = 4'd2 + nbits + {3'b000, cfg_i.par_en} + {3'b000, cfg_i.stop2};

  always_comb begin
    frame_d    = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nbits)) frame_d[i+1] = data_i[i];
    end
    if (cfg_i.par_en) frame_d[nbits + 4'd1] = par_bit;
  end

  assign ending = busy_q && tick_i && (sub_q == 4'd15) && (left_q == 4'd1);
  assign load   = tick_i && avail_i && (!busy_q || ending);
  assign pop_o  = load;
  assign busy_o = busy_q;
  assign txd_o  = busy_q ? frame_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '1;
      left_q  <= '0;
      sub_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      frame_q <= frame_d;
      left_q  <= len_d;
      sub_q   <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (sub_q == 4'd15) begin
        sub_q   <= '0;
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        left_q  <= left_q - 1'b1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned HI_W  = DIV_W - 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       txd_o,
  output logic       thr_empty_o,
  output logic       tx_empty_o,
  output logic       irq_o
);
  logic [DIV_W-1:0] div_q;
  line_cfg_t        line_q;
  logic             q_en_q, ie_q, pre_q;
  logic             baud_tick, flush, push, pop, q_empty, busy;
  logic [7:0]       q_data;
  logic [LVL_W-1:0] fifo_level;

  assign push  = wr_i && (addr_i == REG_DATA);
  assign flush = wr_i && (addr_i == REG_QUEUE) && (wdata_i[0] != q_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      line_q <= '0;
      q_en_q <= 1'b0;
      ie_q   <= 1'b0;
      pre_q  <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        REG_DIV_LO: div_q[7:0]       <= wdata_i;
        REG_DIV_HI: div_q[DIV_W-1:8] <= wdata_i[HI_W-1:0];
        REG_LINE:   line_q           <= wdata_i[4:0];
        REG_QUEUE:  q_en_q           <= wdata_i[0];
        REG_INT_EN: ie_q             <= wdata_i[1];
        REG_CLK:    pre_q            <= wdata_i[7];
        default: ;
      endcase
    end
  end

  uart_baud_gen #(.DIV_W(DIV_W), .PRE_W(2)) u_baud (
    .clk_i, .rst_ni, .div_i(div_q), .pre_en_i(pre_q), .tick_o(baud_tick)
  );

  uart_tx_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .q_en_i(q_en_q), .flush_i(flush), .push_i(push),
    .data_i(wdata_i), .pop_i(pop), .data_o(q_data), .empty_o(q_empty),
    .level_o(fifo_level)
  );

  uart_tx_shifter u_shift (
    .clk_i, .rst_ni, .tick_i(baud_tick), .cfg_i(line_q), .avail_i(!q_empty),
    .data_i(q_data), .pop_o(pop), .busy_o(busy), .txd_o(txd_o)
  );

  assign thr_empty_o = q_empty;
  assign tx_empty_o  = q_empty && !busy;
  assign irq_o       = ie_q && q_empty;
endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             txd_o,
  input logic             thr_empty_o,
  input logic             tx_empty_o,
  input logic             irq_o,
  input logic             baud_tick,
  input logic [DIV_W-1:0] div_q,
  input logic [LVL_W-1:0] fifo_level,
  input logic             q_en_q
);
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> txd_o);

  p_flag_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> thr_empty_o);

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> thr_empty_o);

  p_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0) |=> $stable(txd_o));

  p_edge_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txd_o) |-> $past(baud_tick));

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= (q_en_q ? LVL_W'(DEPTH) : LVL_W'(1)));
endmodule

bind uart_tx_path uart_tx_path_chk #(.DIV_W(DIV_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_tx_path_test.sv
module uart_tx_path_test;
  localparam int CLK_P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       txd_o, thr_empty_o, tx_empty_o, irq_o;

  int errs = 0, checks = 0, cyc = 0, fall_cyc = 0;
  bit done = 0;

  uart_tx_path uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  function automatic logic [7:0] line(input int nb, input bit pe, po, s2);
    return {3'b000, po, pe, s2, 2'(nb - 5)};
  endfunction

  // receive one frame; if last, also check time from start edge to tx_empty
  task automatic recv(input int nb, input bit pe, po, s2, input int cpb,
                      input bit last, input logic [7:0] exp, input string req);
    int n = 0;
    logic [7:0] got = '0;
    logic [7:0] m = 8'hFF >> (8 - nb);
    int len = 2 + nb + int'(pe) + int'(s2);
    while (txd_o !== 1'b0) @(negedge clk_i);
    fall_cyc = cyc;
    repeat (cpb/2) begin @(negedge clk_i); n++; end
    chk(txd_o == 1'b0, {req, " start bit"}, txd_o, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (cpb) begin @(negedge clk_i); n++; end
      got[i] = txd_o;
    end
    chk(got == (exp & m), {req, " data"}, got, exp & m);
    if (pe) begin
      repeat (cpb) begin @(negedge clk_i); n++; end
      chk(txd_o == ((^(exp & m)) ^ po), "R3 parity bit", txd_o, (^(exp & m)) ^ po);
    end
    repeat (cpb) begin @(negedge clk_i); n++; end
    chk(txd_o == 1'b1, "R4 stop bit", txd_o, 1);
    if (last) begin
      while (!tx_empty_o) begin @(negedge clk_i); n++; end
      chk(n == len * cpb, "R4 frame length", n, len * cpb);
    end
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(txd_o == 1 && thr_empty_o == 1 && tx_empty_o == 1 && irq_o == 0,
        "R1 reset state", {txd_o, thr_empty_o, tx_empty_o, irq_o}, 4'b1110);
  endtask

  task automatic t_formats;
    wr(3'd1, 8'd1);
    wr(3'd3, line(8, 0, 0, 0));
    wr(3'd0, 8'hA5);
    recv(8, 0, 0, 0, 16, 1, 8'hA5, "R2 8N1");
    wr(3'd3, line(5, 1, 1, 1));
    wr(3'd0, 8'hF3);
    recv(5, 1, 1, 1, 16, 1, 8'hF3, "R2 5O2");
    wr(3'd3, line(6, 1, 0, 0));
    wr(3'd0, 8'h2D);
    recv(6, 1, 0, 0, 16, 1, 8'h2D, "R3 6E1");
    wr(3'd3, line(7, 0, 0, 1));
    wr(3'd0, 8'hD5);
    recv(7, 0, 0, 1, 16, 1, 8'hD5, "R4 7N2");
    wr(3'd3, line(8, 0, 0, 0));
  endtask

  task automatic t_divisor;
    int n = 0;
    wr(3'd1, 8'd3);
    wr(3'd0, 8'h3C);
    recv(8, 0, 0, 0, 48, 1, 8'h3C, "R5 divisor 3");
    wr(3'd2, 8'd1);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'hFF);
    while (txd_o !== 1'b0) @(negedge clk_i);
    while (txd_o == 1'b0) begin @(negedge clk_i); n++; end
    chk(n == 4096, "R5 high byte divisor start bit", n, 4096);
    wr(3'd2, 8'd0);
    wr(3'd1, 8'd1);
    while (!tx_empty_o) @(negedge clk_i);
  endtask

  task automatic t_prescale;
    wr(3'd6, 8'h80);
    wr(3'd0, 8'h96);
    recv(8, 0, 0, 0, 64, 1, 8'h96, "R6 prescale");
    wr(3'd6, 8'h00);
  endtask

  task automatic t_halt;
    bit moved = 0;
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h5A);
    repeat (300) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1) moved = 1;
    end
    chk(!moved && !tx_empty_o, "R7 divisor 0 holds line", {moved, tx_empty_o}, 0);
    wr(3'd1, 8'd1);
    recv(8, 0, 0, 0, 16, 1, 8'h5A, "R7 resume");
  endtask

  task automatic t_queue;
    int prev = 0;
    bit moved = 0;
    wr(3'd4, 8'h01);
    wr(3'd1, 8'd0);
    for (int i = 0; i < 17; i++) wr(3'd0, 8'(i * 7 + 3));
    wr(3'd1, 8'd1);
    for (int i = 0; i < 16; i++) begin
      recv(8, 0, 0, 0, 16, 0, 8'(i * 7 + 3), "R8 queue order");
      if (i > 0) chk(fall_cyc - prev == 160, "R12 back-to-back start", fall_cyc - prev, 160);
      prev = fall_cyc;
    end
    while (!tx_empty_o) @(negedge clk_i);
    repeat (300) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1 || !tx_empty_o) moved = 1;
    end
    chk(!moved, "R8 17th write dropped", moved, 0);
  endtask

  task automatic t_single;
    bit moved = 0;
    wr(3'd4, 8'h00);
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h11);
    wr(3'd0, 8'h22);
    wr(3'd1, 8'd1);
    recv(8, 0, 0, 0, 16, 1, 8'h11, "R9 single holding");
    repeat (300) begin
      @(negedge clk_i);
      if (txd_o !== 1'b1) moved = 1;
    end
    chk(!moved, "R9 second write dropped", moved, 0);
  endtask

  task automatic t_status;
    wr(3'd1, 8'd0);
    wr(3'd5, 8'h02);
    @(negedge clk_i);
    chk(irq_o == 1, "R11 irq when empty and enabled", irq_o, 1);
    wr(3'd0, 8'h77);
    chk(thr_empty_o == 0 && tx_empty_o == 0 && irq_o == 0, "R10 flags after write",
        {thr_empty_o, tx_empty_o, irq_o}, 0);
    wr(3'd1, 8'd1);
    while (txd_o !== 1'b0) @(negedge clk_i);
    chk(thr_empty_o == 1 && tx_empty_o == 0 && irq_o == 1, "R10 flags after handoff",
        {thr_empty_o, tx_empty_o, irq_o}, 3'b101);
    wr(3'd5, 8'h00);
    chk(irq_o == 0, "R11 irq masked", irq_o, 0);
    while (!tx_empty_o) @(negedge clk_i);
    chk(txd_o == 1 && thr_empty_o == 1, "R10 fully empty", {txd_o, thr_empty_o}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_formats();
    t_divisor();
    t_prescale();
    t_halt();
    t_queue();
    t_single();
    t_status();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule